// File: doc/BRIEF.md
# Interrupt Controller Command Decoder and Initialization Sequencer

This block is the register front end of one eight-line interrupt controller. A host reaches it through a one-bit register address, separate read and write strobes and an eight-bit data bus. Writes at address 0 carry either a start-of-initialization word or one of two kinds of operation word. Writes at address 1 carry either the remaining initialization words or a new interrupt mask. Reads return the request, in-service or mask register, or the result of a poll.

The block holds all controller configuration: the vector base, the extended-initialization flag, the nested-mode and automatic end-of-interrupt flags, rotate-on-automatic-end-of-interrupt, read select, the poll arm and special mask. Priority evaluation is outside the block. The neighbouring priority core supplies the request and in-service vectors and the highest pending line. The block sends that core decoded end-of-interrupt and priority commands, a clear pulse for initialization, and a clear pulse for the line taken by a poll. All strobes are combinational and are valid in the cycle of the access. All stored state changes at the following clock edge.

Top module: `irqc_regif`

## Requirements
- R1: After synchronous reset the sequencer phase is 0, and the mask, vector base, every flag, read select and the poll arm are all 0.
- R2: A write at address 0 with bit 4 set pulses `init_clr` in its own cycle. On the next edge it sets the phase to 1, sets `four_word` to data bit 0, and clears the mask, vector base, read select, poll arm, special mask and the nested, automatic and rotate flags.
- R3: In phase 1 a write at address 1 stores data AND 0xF8 as the vector base and moves to phase 2. The mask is unchanged.
- R4: In phase 2 a write at address 1 moves to phase 3 when `four_word` is 1 and to phase 0 otherwise.
- R5: In phase 3 a write at address 1 sets `sfnm_en` from data bit 4 and `aeoi_en` from data bit 1, then returns to phase 0.
- R6: In phase 0 a write at address 1 loads the whole data byte into the mask.
- R7: A write at address 0 with bit 4 clear and bit 3 set is a mode word. Bit 2 set arms poll. Bit 1 set copies bit 0 into read select (1 selects in-service, 0 selects request). Bit 6 set copies bit 5 into special mask. Fields whose enable bit is clear keep their value.
- R8: A write at address 0 with bits 4 and 3 clear carries a command code in bits 7:5. Codes 0 and 4 copy data bit 7 into `rot_aeoi_en`. Code 2 changes nothing. None of codes 0, 2 and 4 raises `cmd_stb`.
- R9: Command codes 1, 3, 5, 6 and 7 raise `cmd_stb` in the write cycle, with `cmd_code` equal to data bits 7:5 and `cmd_level` equal to data bits 2:0.
- R10: While poll is armed, a read at either address returns `pend_line` when `pend_valid` is 1 and 0 otherwise. In that same cycle `poll_clr` is raised with `poll_line` = `pend_line` only if `pend_valid` is 1. Poll is disarmed on the next edge.
- R11: Without poll, a read at address 0 returns `isr_vec` when read select is 1 and `req_vec` when it is 0. A read at address 1 returns the mask. `rdata` is 0 when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| req_vec | input | 8 | Request register from the priority core |
| isr_vec | input | 8 | In-service register from the priority core |
| pend_valid | input | 1 | Priority core has a line to deliver |
| pend_line | input | 3 | Number of that line |
| mask_vec | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| init_phase | output | 2 | Initialization sequencer phase |
| four_word | output | 1 | Fourth initialization word expected |
| sfnm_en | output | 1 | Special fully nested mode |
| aeoi_en | output | 1 | Automatic end of interrupt |
| rot_aeoi_en | output | 1 | Rotate on automatic end of interrupt |
| spec_mask_en | output | 1 | Special mask mode |
| rd_isr_sel | output | 1 | Read select, 1 = in-service |
| poll_armed | output | 1 | Next read is a poll |
| init_clr | output | 1 | Pulse: clear core state for initialization |
| cmd_stb | output | 1 | Pulse: priority command valid |
| cmd_code | output | 3 | Command code for the core |
| cmd_level | output | 3 | Line operand for the command |
| poll_clr | output | 1 | Pulse: clear request and in-service of poll_line |
| poll_line | output | 3 | Line cleared by the poll |

## Verification
The properties assume the host never raises read and write in the same cycle. The poll-disarm and phase-step properties depend on that separation, and the bench drives the two strobes as mutually exclusive in every sequence, including the random one. They also assume that `pend_line` is meaningful only while `pend_valid` is high. The bench varies `pend_line` freely when `pend_valid` is low, so the zero-return path of a poll is exercised with a live but ignored line number.

// File: rtl/irqc_pkg.sv
// Shared types and field positions for the interrupt controller register front end.
// Assumes an 8-bit host data bus and eight request lines.
package irqc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BASE = 2'd1,
        PH_CASC = 2'd2,
        PH_MODE = 2'd3
    } init_phase_e;

    localparam int BIT_INIT   = 4;
    localparam int BIT_MODEW  = 3;
    localparam int BIT_POLL   = 2;
    localparam int BIT_SELEN  = 1;
    localparam int BIT_SEL    = 0;
    localparam int BIT_SMMEN  = 6;
    localparam int BIT_SMM    = 5;
    localparam int BIT_FOUR   = 0;
    localparam int BIT_NEST   = 4;
    localparam int BIT_AEOI   = 1;
    localparam int BIT_ROT    = 7;

    localparam logic [2:0] CODE_ROT_CLR = 3'd0;
    localparam logic [2:0] CODE_NOP     = 3'd2;
    localparam logic [2:0] CODE_ROT_SET = 3'd4;
endpackage

// File: rtl/irqc_op_decode.sv
// Decodes host writes at address 0 and holds the mode-word state.
// Assumes wr_en and rd_en are never high together.
module irqc_op_decode
    import irqc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              poll_taken,
    output logic              icw_start,
    output logic              data_wr,
    output logic              rot_aeoi_en,
    output logic              spec_mask_en,
    output logic              rd_isr_sel,
    output logic              poll_armed,
    output logic              cmd_stb,
    output logic [2:0]        cmd_code,
    output logic [LINE_W-1:0] cmd_level
);
    localparam int CODE_LSB = DATA_W - 3;

    logic ctrl_wr, mode_wr, cmd_wr;

    // Classify the write by address and the two type bits.
    always_comb begin
        ctrl_wr   = wr_en && !reg_addr;
        icw_start = ctrl_wr && wdata[BIT_INIT];
        mode_wr   = ctrl_wr && !wdata[BIT_INIT] && wdata[BIT_MODEW];
        cmd_wr    = ctrl_wr && !wdata[BIT_INIT] && !wdata[BIT_MODEW];
        data_wr   = wr_en && reg_addr;
        cmd_code  = wdata[DATA_W-1:CODE_LSB];
        cmd_level = wdata[LINE_W-1:0];
        cmd_stb   = cmd_wr && (cmd_code != CODE_ROT_CLR) && (cmd_code != CODE_ROT_SET)
                    && (cmd_code != CODE_NOP);
    end

    // Mode-word state: cleared by reset or init, updated by enabled fields.
    always_ff @(posedge clk) begin
        if (!rst_n || icw_start) begin
            rot_aeoi_en  <= 1'b0;
            spec_mask_en <= 1'b0;
            rd_isr_sel   <= 1'b0;
            poll_armed   <= 1'b0;
        end else begin
            if (mode_wr) begin
                if (wdata[BIT_POLL])  poll_armed   <= 1'b1;
                if (wdata[BIT_SELEN]) rd_isr_sel   <= wdata[BIT_SEL];
                if (wdata[BIT_SMMEN]) spec_mask_en <= wdata[BIT_SMM];
            end else if (poll_taken) begin
                poll_armed <= 1'b0;
            end
            if (cmd_wr && (cmd_code == CODE_ROT_CLR || cmd_code == CODE_ROT_SET))
                rot_aeoi_en <= wdata[BIT_ROT];
        end
    end
endmodule

// File: rtl/irqc_init_seq.sv
// Four-phase initialization sequencer plus the mask register.
// Assumes icw_start and data_wr are never high together.
module irqc_init_seq
    import irqc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              icw_start,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [1:0]        init_phase,
    output logic [DATA_W-1:0] vec_base,
    output logic              four_word,
    output logic              sfnm_en,
    output logic              aeoi_en,
    output logic [DATA_W-1:0] mask_vec
);
    localparam logic [DATA_W-1:0] BASE_KEEP = ~DATA_W'((1 << LINE_W) - 1);

    init_phase_e phase_q;

    assign init_phase = phase_q;

    // Phase walk and configuration capture for address-1 writes.
    always_ff @(posedge clk) begin
        if (!rst_n || icw_start) begin
            phase_q   <= rst_n ? PH_BASE : PH_IDLE;
            four_word <= rst_n && wdata[BIT_FOUR];
            vec_base  <= '0;
            sfnm_en   <= 1'b0;
            aeoi_en   <= 1'b0;
            mask_vec  <= '0;
        end else if (data_wr) begin
            case (phase_q)
                PH_IDLE: mask_vec <= wdata;
                PH_BASE: begin
                    vec_base <= wdata & BASE_KEEP;
                    phase_q  <= PH_CASC;
                end
                PH_CASC: phase_q <= four_word ? PH_MODE : PH_IDLE;
                PH_MODE: begin
                    sfnm_en <= wdata[BIT_NEST];
                    aeoi_en <= wdata[BIT_AEOI];
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irqc_read_path.sv
// Read-data selection and one-shot poll handling.
// Assumes pend_line is meaningful only while pend_valid is high.
module irqc_read_path #(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input  logic              reg_addr,
    input  logic              rd_en,
    input  logic              poll_armed,
    input  logic              rd_isr_sel,
    input  logic [DATA_W-1:0] req_vec,
    input  logic [DATA_W-1:0] isr_vec,
    input  logic [DATA_W-1:0] mask_vec,
    input  logic              pend_valid,
    input  logic [LINE_W-1:0] pend_line,
    output logic [DATA_W-1:0] rdata,
    output logic              poll_taken,
    output logic              poll_clr,
    output logic [LINE_W-1:0] poll_line
);
    // Pick the returned byte and raise the poll side effects.
    always_comb begin
        poll_taken = rd_en && poll_armed;
        poll_clr   = poll_taken && pend_valid;
        poll_line  = pend_line;
        rdata      = '0;
        if (poll_taken)
            rdata = pend_valid ? DATA_W'(pend_line) : '0;
        else if (rd_en)
            rdata = reg_addr ? mask_vec : (rd_isr_sel ? isr_vec : req_vec);
    end
endmodule

// File: rtl/irqc_regif.sv
// Host register front end of one interrupt controller: decodes command
// words, sequences initialization, and returns register or poll data.
// Assumes the priority core outside supplies request, in-service and pending line.
module irqc_regif #(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] req_vec,
    input  logic [DATA_W-1:0] isr_vec,
    input  logic              pend_valid,
    input  logic [LINE_W-1:0] pend_line,
    output logic [DATA_W-1:0] mask_vec,
    output logic [DATA_W-1:0] vec_base,
    output logic [1:0]        init_phase,
    output logic              four_word,
    output logic              sfnm_en,
    output logic              aeoi_en,
    output logic              rot_aeoi_en,
    output logic              spec_mask_en,
    output logic              rd_isr_sel,
    output logic              poll_armed,
    output logic              init_clr,
    output logic              cmd_stb,
    output logic [2:0]        cmd_code,
    output logic [LINE_W-1:0] cmd_level,
    output logic              poll_clr,
    output logic [LINE_W-1:0] poll_line
);
    logic icw_start, data_wr, poll_taken;

    assign init_clr = icw_start;

    irqc_op_decode #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .wdata(wdata),
        .poll_taken(poll_taken), .icw_start(icw_start), .data_wr(data_wr),
        .rot_aeoi_en(rot_aeoi_en), .spec_mask_en(spec_mask_en), .rd_isr_sel(rd_isr_sel),
        .poll_armed(poll_armed), .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_level(cmd_level)
    );

    irqc_init_seq #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .icw_start(icw_start), .data_wr(data_wr), .wdata(wdata),
        .init_phase(init_phase), .vec_base(vec_base), .four_word(four_word),
        .sfnm_en(sfnm_en), .aeoi_en(aeoi_en), .mask_vec(mask_vec)
    );

    irqc_read_path #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_rd (
        .reg_addr(reg_addr), .rd_en(rd_en), .poll_armed(poll_armed), .rd_isr_sel(rd_isr_sel),
        .req_vec(req_vec), .isr_vec(isr_vec), .mask_vec(mask_vec),
        .pend_valid(pend_valid), .pend_line(pend_line), .rdata(rdata),
        .poll_taken(poll_taken), .poll_clr(poll_clr), .poll_line(poll_line)
    );
endmodule

// File: rtl/irqc_regif_chk.sv
// Property checker for irqc_regif, attached by bind.
// Assumes read and write strobes are mutually exclusive.
module irqc_regif_chk #(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] mask_vec,
    input logic [DATA_W-1:0] vec_base,
    input logic [1:0]        init_phase,
    input logic              four_word,
    input logic              sfnm_en,
    input logic              aeoi_en,
    input logic              rd_isr_sel,
    input logic              poll_armed,
    input logic              init_clr,
    input logic              cmd_stb,
    input logic [2:0]        cmd_code,
    input logic              pend_valid,
    input logic [LINE_W-1:0] pend_line,
    input logic              poll_clr,
    input logic [LINE_W-1:0] poll_line
);
    localparam logic [DATA_W-1:0] BASE_KEEP = ~DATA_W'((1 << LINE_W) - 1);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (init_phase == 2'd0 && mask_vec == '0 && !rd_isr_sel && !poll_armed));

    p_init_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_addr && wdata[4]) |=>
        (init_phase == 2'd1 && mask_vec == '0 && !poll_armed && four_word == $past(wdata[0])));

    p_base_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr && init_phase == 2'd1) |=>
        (vec_base == ($past(wdata) & BASE_KEEP) && init_phase == 2'd2 && $stable(mask_vec)));

    p_fourth_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr && init_phase == 2'd2) |=>
        (init_phase == ($past(four_word) ? 2'd3 : 2'd0)));

    p_mode_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr && init_phase == 2'd3) |=>
        (init_phase == 2'd0 && sfnm_en == $past(wdata[4]) && aeoi_en == $past(wdata[1])));

    p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr && init_phase == 2'd0) |=> (mask_vec == $past(wdata)));

    p_cmd_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (wr_en && !reg_addr && wdata[4:3] == 2'b00 &&
                     cmd_code != 3'd0 && cmd_code != 3'd2 && cmd_code != 3'd4));

    p_poll_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && poll_armed) |=> !poll_armed);

    p_poll_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        poll_clr |-> (rd_en && poll_armed && pend_valid && poll_line == pend_line));

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_clr, cmd_stb, poll_clr}));

    p_no_rw_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));
endmodule

bind irqc_regif irqc_regif_chk #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .mask_vec(mask_vec), .vec_base(vec_base), .init_phase(init_phase),
    .four_word(four_word), .sfnm_en(sfnm_en), .aeoi_en(aeoi_en), .rd_isr_sel(rd_isr_sel),
    .poll_armed(poll_armed), .init_clr(init_clr), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .pend_valid(pend_valid), .pend_line(pend_line), .poll_clr(poll_clr), .poll_line(poll_line)
);

// File: tb/irqc_regif_bench.sv
// Bench for irqc_regif: behavioural reference model compared every clock.
module irqc_regif_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, req_vec = '0, isr_vec = '0;
    logic       pend_valid = 1'b0;
    logic [2:0] pend_line = '0;
    logic [7:0] rdata, mask_vec, vec_base;
    logic [1:0] init_phase;
    logic       four_word, sfnm_en, aeoi_en, rot_aeoi_en, spec_mask_en, rd_isr_sel, poll_armed;
    logic       init_clr, cmd_stb, poll_clr;
    logic [2:0] cmd_code, cmd_level, poll_line;

    int compared = 0, mismatched = 0;
    bit finished = 0;

    // Reference state.
    int m_phase, m_four, m_base, m_mask, m_nest, m_aeoi, m_rot, m_smm, m_sel, m_poll;

    always #5 clk = ~clk;

    irqc_regif u_irqc_regif (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .req_vec(req_vec), .isr_vec(isr_vec),
        .pend_valid(pend_valid), .pend_line(pend_line), .mask_vec(mask_vec),
        .vec_base(vec_base), .init_phase(init_phase), .four_word(four_word),
        .sfnm_en(sfnm_en), .aeoi_en(aeoi_en), .rot_aeoi_en(rot_aeoi_en),
        .spec_mask_en(spec_mask_en), .rd_isr_sel(rd_isr_sel), .poll_armed(poll_armed),
        .init_clr(init_clr), .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_level(cmd_level),
        .poll_clr(poll_clr), .poll_line(poll_line)
    );

    task automatic chk(string req, string what, int act, int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model for the inputs now applied.
    task automatic compare_all();
        int code, exp_rd, is_cmd;
        code = int'(wdata) >> 5;
        is_cmd = (wr_en && !reg_addr && !wdata[4] && !wdata[3] &&
                  code != 0 && code != 2 && code != 4) ? 1 : 0;
        if (!rd_en) exp_rd = 0;
        else if (m_poll != 0) exp_rd = pend_valid ? int'(pend_line) : 0;
        else if (reg_addr) exp_rd = m_mask;
        else exp_rd = (m_sel != 0) ? int'(isr_vec) : int'(req_vec);
        chk("R1", "init_phase", int'(init_phase), m_phase);
        chk("R2", "four_word", int'(four_word), m_four);
        chk("R2", "init_clr", int'(init_clr), (wr_en && !reg_addr && wdata[4]) ? 1 : 0);
        chk("R3", "vec_base", int'(vec_base), m_base);
        chk("R5", "sfnm_en", int'(sfnm_en), m_nest);
        chk("R5", "aeoi_en", int'(aeoi_en), m_aeoi);
        chk("R6", "mask_vec", int'(mask_vec), m_mask);
        chk("R7", "rd_isr_sel", int'(rd_isr_sel), m_sel);
        chk("R7", "spec_mask_en", int'(spec_mask_en), m_smm);
        chk("R7", "poll_armed", int'(poll_armed), m_poll);
        chk("R8", "rot_aeoi_en", int'(rot_aeoi_en), m_rot);
        chk("R9", "cmd_stb", int'(cmd_stb), is_cmd);
        if (is_cmd != 0) begin
            chk("R9", "cmd_code", int'(cmd_code), code);
            chk("R9", "cmd_level", int'(cmd_level), int'(wdata[2:0]));
        end
        chk("R10", "poll_clr", int'(poll_clr), (rd_en && m_poll != 0 && pend_valid) ? 1 : 0);
        if (poll_clr) chk("R10", "poll_line", int'(poll_line), int'(pend_line));
        chk("R11", "rdata", int'(rdata), exp_rd);
    endtask

    // Advance the model across one clock edge.
    task automatic model_edge();
        int code;
        code = int'(wdata) >> 5;
        if (!rst_n) begin
            m_phase = 0; m_four = 0; m_base = 0; m_mask = 0; m_nest = 0;
            m_aeoi = 0; m_rot = 0; m_smm = 0; m_sel = 0; m_poll = 0;
        end else if (wr_en && !reg_addr && wdata[4]) begin
            m_phase = 1; m_four = int'(wdata[0]); m_base = 0; m_mask = 0; m_nest = 0;
            m_aeoi = 0; m_rot = 0; m_smm = 0; m_sel = 0; m_poll = 0;
        end else if (wr_en && !reg_addr && wdata[3]) begin
            if (wdata[2]) m_poll = 1;
            if (wdata[1]) m_sel = int'(wdata[0]);
            if (wdata[6]) m_smm = int'(wdata[5]);
        end else if (wr_en && !reg_addr) begin
            if (code == 0 || code == 4) m_rot = int'(wdata[7]);
        end else if (wr_en && reg_addr) begin
            case (m_phase)
                0: m_mask = int'(wdata);
                1: begin m_base = int'(wdata) & 'hF8; m_phase = 2; end
                2: m_phase = (m_four != 0) ? 3 : 0;
                default: begin m_nest = int'(wdata[4]); m_aeoi = int'(wdata[1]); m_phase = 0; end
            endcase
        end else if (rd_en && m_poll != 0) begin
            m_poll = 0;
        end
    endtask

    task automatic step(bit a, bit w, bit r, logic [7:0] d);
        reg_addr = a; wr_en = w; rd_en = r; wdata = d;
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic wr(bit a, logic [7:0] d); step(a, 1'b1, 1'b0, d); endtask
    task automatic rd(bit a);                step(a, 1'b0, 1'b1, 8'h00); endtask
    task automatic idle();                   step(1'b0, 1'b0, 1'b0, 8'h00); endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            mismatched++; compared++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset, then compare from a settled state.
        repeat (3) @(posedge clk);
        model_edge();
        @(negedge clk);
        idle();
        rst_n = 1'b1;
        idle();
        // R2..R5: four-word initialization, mask write during phase 1 ignored (R3).
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h47);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h12);
        idle();
        // R6, R11: mask load and read-back.
        wr(1'b1, 8'hA5);
        req_vec = 8'h3C; isr_vec = 8'h81;
        rd(1'b1);
        rd(1'b0);
        // R7: select in-service, then a word with select disabled keeps it.
        wr(1'b0, 8'h0B);
        rd(1'b0);
        wr(1'b0, 8'h09);
        rd(1'b0);
        wr(1'b0, 8'h0A);
        rd(1'b0);
        wr(1'b0, 8'h68);
        wr(1'b0, 8'h28);
        wr(1'b0, 8'h48);
        // R10: poll with a pending line, then with none.
        pend_valid = 1'b1; pend_line = 3'd5;
        wr(1'b0, 8'h0C);
        rd(1'b1);
        rd(1'b0);
        pend_valid = 1'b0; pend_line = 3'd6;
        wr(1'b0, 8'h0C);
        rd(1'b0);
        // R8, R9: every command code.
        for (int c = 0; c < 8; c++) wr(1'b0, 8'((c << 5) | 3'(c)));
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h40);
        wr(1'b0, 8'h00);
        // R4: three-word initialization skips the mode word; R2 clears mask.
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h2F);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h5A);
        rd(1'b1);
        // Random mix, read and write kept exclusive.
        for (int i = 0; i < 400; i++) begin
            int k;
            req_vec = 8'($urandom); isr_vec = 8'($urandom);
            pend_valid = 1'($urandom); pend_line = 3'($urandom);
            k = $urandom_range(0, 3);
            if (k == 0) rd(1'($urandom));
            else if (k == 3) idle();
            else wr(1'($urandom), 8'($urandom));
        end
        // R1: reset mid-run returns to defaults.
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        idle();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule